// File: doc/BRIEF.md
# Capture/Compare Timer

A 16-bit free-running counter with two input-capture channels, two output-compare channels, a pulse-width mode and a single-shot mode. The counter advances on a count tick. The tick comes either from a programmable divider on the bus clock or from rising edges of a slow external clock pin. That pin is brought into the bus clock domain through a synchroniser, so the whole block runs on one clock.

Firmware reaches the block through a flat register port: a write strobe, an address, write data and combinational read data. Capture, compare and counter-wrap events set sticky status flags that firmware clears by writing ones. The flags are combined into one interrupt line through per-flag enables. Capture and compare events can also raise a one-cycle request for a DMA controller. Compare channel 1 can fire a one-cycle start pulse towards an ADC.

Top module: `cctimer`

## Requirements
- R1: After reset, the counter, both capture registers and the status register read 0, and `oc_out`, `irq`, `dma_req` and `adc_trig` are low.
- R2: With the internal source selected and the run bit (CTRL[0]) set, the counter advances by one every DIV+1 bus clocks, where DIV is the divider register (address 1, bits 7:0). With the run bit clear, the counter holds its value.
- R3: Outside the pulse-width mode, the counter wraps from 0xFFFF to 0x0000 and sets the wrap flag (STATUS bit 4).
- R4: With CTRL[1] set, the counter advances once per rising edge of `ext_clk`, seen through a two-flop synchroniser, and the divider has no effect.
- R5: Each capture channel n latches the counter into its capture register (addresses 4 and 5) and sets STATUS bit n-1 on the edge chosen by its select field (channel 1 CTRL[7:6], channel 2 CTRL[9:8]): 00 none, 01 rising, 10 falling, 11 both.
- R6: On a tick while the counter equals compare register n (addresses 2 and 3), STATUS bit n+1 is set and `oc_out[n-1]` toggles. `oc_out[0]` only toggles in this way outside the pulse-width and single-shot modes.
- R7: In pulse-width mode (CTRL[2]), the counter restarts at 0 on the tick after it equals compare 2, so it never exceeds compare 2. `oc_out[0]` is high while the counter is below compare 1.
- R8: In single-shot mode (CTRL[3]), the counter waits at 0 until a rising edge on `trig_in`. `oc_out[0]` is then high for compare-1 + 1 ticks, after which the counter returns to 0 and waits for the next edge.
- R9: Status flags stay set until a write to address 6 with a one in their bit position. `irq` is the OR of the status bits masked by CTRL[14:10] (bit 10 + k enables status bit k).
- R10: With CTRL[4] set, every capture or compare event produces a one-cycle `dma_req` pulse. With the bit clear, no pulse is produced.
- R11: With CTRL[5] set, every compare-1 event produces a one-cycle `adc_trig` pulse.
- R12: Control (address 0), divider (address 1), compare and counter (address 7) registers read back what was written. A counter write takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| ext_clk | input | 1 | External count clock, asynchronous |
| cap_in | input | 2 | Capture inputs, asynchronous |
| trig_in | input | 1 | Single-shot start input, asynchronous |
| oc_out | output | 2 | Compare / PWM / pulse outputs |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA single-transfer request pulse |
| adc_trig | output | 1 | ADC conversion start pulse |

## Verification
The bench aims at the divider phase: with a divide of four, a wrong reload value or a divider that does not reset when stopped gives a count off by one after a fixed number of cycles. It runs the counter across 0xFFFF, where a missing wrap or a missing flag shows up in the count and status reads. It drives each capture edge select against both edge directions, so a swapped or ignored encoding latches the wrong count or sets a stray flag. It measures pulse-width duty and single-shot length in cycles against a held trigger, which catches an off-by-one period, a counter that overruns compare 2, and a single-shot that retriggers on a level.

// File: rtl/cctimer_pkg.sv
package cctimer_pkg;

  localparam int ADDR_W = 3;
  localparam int N_CH   = 2;
  localparam int N_FLAG = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_DIV  = 3'd1,
    REG_CMP1 = 3'd2,
    REG_CMP2 = 3'd3,
    REG_CAP1 = 3'd4,
    REG_CAP2 = 3'd5,
    REG_STAT = 3'd6,
    REG_CNT  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // control word, LSB is run
  typedef struct packed {
    logic [N_FLAG-1:0] ien;
    edge_sel_e         edge2;
    edge_sel_e         edge1;
    logic              adc_en;
    logic              dma_en;
    logic              opm;
    logic              pwm;
    logic              ext_sel;
    logic              run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // status bit positions
  localparam int F_CAP1 = 0;
  localparam int F_CAP2 = 1;
  localparam int F_CMP1 = 2;
  localparam int F_CMP2 = 3;
  localparam int F_WRAP = 4;

endpackage

// File: rtl/cctimer_sync.sv
module cctimer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr_q, sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];

endmodule

// File: rtl/cctimer_tick.sv
module cctimer_tick #(
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ext_sel,
  input  logic [PSC_W-1:0] div,
  input  logic             ext_clk,
  output logic             tick
);

  logic [PSC_W-1:0] pcnt_q, pcnt_d;
  logic             ext_s, ext_prev_q;
  logic             int_tick, ext_tick;

  cctimer_sync #(.STAGES(SYNC_STAGES)) i_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_clk), .q(ext_s)
  );

  always_comb begin
    int_tick = run && !ext_sel && (pcnt_q >= div);
    ext_tick = run && ext_sel && ext_s && !ext_prev_q;
    pcnt_d   = pcnt_q;
    if (!run || ext_sel) pcnt_d = '0;
    else if (int_tick)   pcnt_d = '0;
    else                 pcnt_d = pcnt_q + 1'b1;
    tick = int_tick || ext_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q     <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      pcnt_q     <= pcnt_d;
      ext_prev_q <= ext_s;
    end
  end

endmodule

// File: rtl/cctimer_capture.sv
module cctimer_capture
  import cctimer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  edge_sel_e        sel,
  input  logic [CNT_W-1:0] count,
  output logic             evt,
  output logic [CNT_W-1:0] value
);

  logic             pin_s, prev_q;
  logic             rise, fall;
  logic [CNT_W-1:0] val_q, val_d;

  cctimer_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
  );

  always_comb begin
    rise = pin_s && !prev_q;
    fall = !pin_s && prev_q;
    case (sel)
      EDGE_OFF:  evt = 1'b0;
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      default:   evt = rise || fall;
    endcase
    val_d = evt ? count : val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      val_q  <= '0;
    end else begin
      prev_q <= pin_s;
      val_q  <= val_d;
    end
  end

  assign value = val_q;

endmodule

// File: rtl/cctimer_counter.sv
module cctimer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pwm,
  input  logic             opm,
  input  logic             trig_rise,
  input  logic [CNT_W-1:0] cmp1,
  input  logic [CNT_W-1:0] cmp2,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             evt_cmp1,
  output logic             evt_cmp2,
  output logic             evt_wrap,
  output logic [1:0]       oc
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic [1:0]       oc_q, oc_d;
  logic             cnt_en, pwm_end, opm_end;

  always_comb begin
    cnt_en   = tick && (!opm || act_q);
    evt_cmp1 = cnt_en && (cnt_q == cmp1);
    evt_cmp2 = cnt_en && (cnt_q == cmp2);
    pwm_end  = pwm && evt_cmp2;
    opm_end  = !pwm && opm && evt_cmp1;
    evt_wrap = pwm ? pwm_end : (cnt_en && (cnt_q == '1));

    cnt_d = cnt_q;
    if (load)                    cnt_d = load_val;
    else if (pwm_end || opm_end) cnt_d = '0;
    else if (cnt_en)             cnt_d = cnt_q + 1'b1;

    act_d = act_q;
    if (!opm || opm_end) act_d = 1'b0;
    else if (trig_rise)  act_d = 1'b1;

    oc_d = oc_q;
    if (evt_cmp1 && !pwm && !opm) oc_d[0] = ~oc_q[0];
    if (evt_cmp2)                 oc_d[1] = ~oc_q[1];

    if (pwm)      oc[0] = (cnt_q < cmp1);
    else if (opm) oc[0] = act_q;
    else          oc[0] = oc_q[0];
    oc[1] = oc_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      oc_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      oc_q  <= oc_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/cctimer.sv
module cctimer
  import cctimer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ext_clk,
  input  logic [N_CH-1:0]   cap_in,
  input  logic              trig_in,
  output logic [N_CH-1:0]   oc_out,
  output logic              irq,
  output logic              dma_req,
  output logic              adc_trig
);

  logic              rst_int_n;
  ctrl_t             ctrl_q, ctrl_d;
  logic [PSC_W-1:0]  div_q, div_d;
  logic [CNT_W-1:0]  cmp_q [N_CH];
  logic [CNT_W-1:0]  cmp_d [N_CH];
  logic [N_FLAG-1:0] stat_q, stat_d, stat_set, stat_clr;
  logic              dma_q, dma_d, adc_q, adc_d;
  logic              tick, trig_s, trig_prev_q;
  logic [CNT_W-1:0]  count_q;
  logic [N_CH-1:0]   cap_evt;
  logic [CNT_W-1:0]  cap_val [N_CH];
  edge_sel_e         edge_sel [N_CH];
  logic              evt_cmp1, evt_cmp2, evt_wrap;
  logic              wr_cnt;

  // asynchronous assert, synchronous release
  cctimer_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  cctimer_tick #(.PSC_W(PSC_W), .SYNC_STAGES(SYNC_STAGES)) i_tick (
    .clk(clk), .rst_n(rst_int_n), .run(ctrl_q.run), .ext_sel(ctrl_q.ext_sel),
    .div(div_q), .ext_clk(ext_clk), .tick(tick)
  );

  cctimer_sync #(.STAGES(SYNC_STAGES)) i_trig_sync (
    .clk(clk), .rst_n(rst_int_n), .d(trig_in), .q(trig_s)
  );

  assign edge_sel[0] = ctrl_q.edge1;
  assign edge_sel[1] = ctrl_q.edge2;

  for (genvar g = 0; g < N_CH; g++) begin : g_cap
    cctimer_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_cap (
      .clk(clk), .rst_n(rst_int_n), .pin(cap_in[g]), .sel(edge_sel[g]),
      .count(count_q), .evt(cap_evt[g]), .value(cap_val[g])
    );
  end

  assign wr_cnt = bus_wr && (reg_addr_e'(bus_addr) == REG_CNT);

  cctimer_counter #(.CNT_W(CNT_W)) i_counter (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .pwm(ctrl_q.pwm), .opm(ctrl_q.opm),
    .trig_rise(trig_s && !trig_prev_q), .cmp1(cmp_q[0]), .cmp2(cmp_q[1]),
    .load(wr_cnt), .load_val(bus_wdata), .count(count_q),
    .evt_cmp1(evt_cmp1), .evt_cmp2(evt_cmp2), .evt_wrap(evt_wrap), .oc(oc_out)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    for (int i = 0; i < N_CH; i++) cmp_d[i] = cmp_q[i];
    stat_clr = '0;
    if (bus_wr) begin
      case (reg_addr_e'(bus_addr))
        REG_CTRL: ctrl_d   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        REG_DIV:  div_d    = bus_wdata[PSC_W-1:0];
        REG_CMP1: cmp_d[0] = bus_wdata;
        REG_CMP2: cmp_d[1] = bus_wdata;
        REG_STAT: stat_clr = bus_wdata[N_FLAG-1:0];
        default:  ;
      endcase
    end
    stat_set         = '0;
    stat_set[F_CAP1] = cap_evt[0];
    stat_set[F_CAP2] = cap_evt[1];
    stat_set[F_CMP1] = evt_cmp1;
    stat_set[F_CMP2] = evt_cmp2;
    stat_set[F_WRAP] = evt_wrap;
    stat_d = (stat_q & ~stat_clr) | stat_set;
    dma_d  = ctrl_q.dma_en && (|stat_set[F_CMP2:F_CAP1]);
    adc_d  = ctrl_q.adc_en && evt_cmp1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q      <= '0;
      div_q       <= '0;
      for (int i = 0; i < N_CH; i++) cmp_q[i] <= '0;
      stat_q      <= '0;
      dma_q       <= 1'b0;
      adc_q       <= 1'b0;
      trig_prev_q <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_d;
      div_q       <= div_d;
      for (int i = 0; i < N_CH; i++) cmp_q[i] <= cmp_d[i];
      stat_q      <= stat_d;
      dma_q       <= dma_d;
      adc_q       <= adc_d;
      trig_prev_q <= trig_s;
    end
  end

  always_comb begin
    case (reg_addr_e'(bus_addr))
      REG_CTRL: bus_rdata = CNT_W'(ctrl_q);
      REG_DIV:  bus_rdata = CNT_W'(div_q);
      REG_CMP1: bus_rdata = cmp_q[0];
      REG_CMP2: bus_rdata = cmp_q[1];
      REG_CAP1: bus_rdata = cap_val[0];
      REG_CAP2: bus_rdata = cap_val[1];
      REG_STAT: bus_rdata = CNT_W'(stat_q);
      default:  bus_rdata = count_q;
    endcase
  end

  assign irq      = |(stat_q & ctrl_q.ien);
  assign dma_req  = dma_q;
  assign adc_trig = adc_q;

endmodule

// File: rtl/cctimer_chk.sv
module cctimer_chk
  import cctimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic [CNT_W-1:0]  count,
  input ctrl_t             ctrl,
  input logic [CNT_W-1:0]  cmp2,
  input logic [N_FLAG-1:0] status,
  input logic              dma_req,
  input logic              adc_trig
);

  logic cnt_wr, stat_wr;
  assign cnt_wr  = wr && (reg_addr_e'(addr) == REG_CNT);
  assign stat_wr = wr && (reg_addr_e'(addr) == REG_STAT);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ctrl.run) && !$past(cnt_wr)) |-> (count == $past(count)));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == '1 && !$past(ctrl.pwm) && !$past(cnt_wr) && count != $past(count))
      |-> (count == '0 && status[F_WRAP]));

  assert_pwm_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl.pwm) && ctrl.pwm && !$past(wr) && $past(count) <= $past(cmp2))
      |-> (count <= cmp2));

  for (genvar k = 0; k < N_FLAG; k++) begin : g_sticky
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status[k]) && !($past(stat_wr) && $past(wdata[k]))) |-> status[k]);
  end

  assert_dma_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(ctrl.dma_en));

  assert_adc_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> status[F_CMP1]);

endmodule

bind cctimer cctimer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_int_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
  .count(count_q), .ctrl(ctrl_q), .cmp2(cmp_q[1]), .status(stat_q),
  .dma_req(dma_req), .adc_trig(adc_trig)
);

// File: tb/test_cctimer.sv
`timescale 1ns/1ps
module test_cctimer;
  import cctimer_pkg::*;

  logic        clk, rst_n, bus_wr, ext_clk, trig_in;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  cap_in, oc_out;
  logic        irq, dma_req, adc_trig;

  cctimer i_cctimer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .cap_in(cap_in), .trig_in(trig_in), .oc_out(oc_out), .irq(irq),
    .dma_req(dma_req), .adc_trig(adc_trig)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    bit          from_bus;
    logic [15:0] act;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  event  sample_ev;
  int    n_chk = 0, n_fail = 0;
  int    dma_cnt = 0, adc_cnt = 0;
  bit    done = 0;

  always @(negedge clk) begin
    if (dma_req)  dma_cnt++;
    if (adc_trig) adc_cnt++;
  end

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(sample_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] a;
        it = sb.pop_front();
        a  = it.from_bus ? bus_rdata : it.act;
        n_chk++;
        if (a !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", it.tag, a, it.exp);
        end
      end
    end
  end

  task automatic push(input bit fb, input logic [15:0] act, input logic [15:0] exp, input string tag);
    item_t it;
    it.from_bus = fb; it.act = act; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    ->sample_ev;
    @(negedge clk);
  endtask

  task automatic chk_reg(input reg_addr_e a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    #1;
    push(1'b1, '0, exp, tag);
  endtask

  task automatic chk_val(input logic [15:0] act, input logic [15:0] exp, input string tag);
    push(1'b0, act, exp, tag);
  endtask

  task automatic wr(input reg_addr_e a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (oc_out[0]) hi++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int hi, mx;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_clk = 1'b0; cap_in = '0; trig_in = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk_reg(REG_CNT,  16'h0, "R1 count");
    chk_reg(REG_STAT, 16'h0, "R1 status");
    chk_reg(REG_CAP1, 16'h0, "R1 cap1");
    chk_val({14'h0, oc_out}, 16'h0, "R1 oc_out");
    chk_val({13'h0, irq, dma_req, adc_trig}, 16'h0, "R1 irq/dma/adc");

    // R12 register readback, R2 counting at divide 1
    wr(REG_CMP1, 16'hFFF0);
    wr(REG_CMP2, 16'hFFF0);
    wr(REG_DIV, 16'h0000);
    chk_reg(REG_CMP1, 16'hFFF0, "R12 cmp1 readback");
    wr(REG_CTRL, 16'h0001);
    idle(10);
    wr(REG_CTRL, 16'h0000);
    chk_reg(REG_CNT, 16'd11, "R2 count after 11 ticks");
    idle(5);
    chk_reg(REG_CNT, 16'd11, "R2 held while stopped");

    // R2 divide by 4
    wr(REG_CNT, 16'h0000);
    wr(REG_DIV, 16'h0003);
    chk_reg(REG_DIV, 16'h0003, "R12 div readback");
    wr(REG_CTRL, 16'h0001);
    idle(12);
    wr(REG_CTRL, 16'h0000);
    chk_reg(REG_CNT, 16'd3, "R2 divide by 4");

    // R3 wrap and flag, R9 interrupt and clearing
    wr(REG_STAT, 16'h001F);
    wr(REG_DIV, 16'h0000);
    wr(REG_CNT, 16'hFFFD);
    chk_reg(REG_CNT, 16'hFFFD, "R12 count load");
    wr(REG_CTRL, 16'h0001);
    idle(2);
    wr(REG_CTRL, 16'h0000);
    chk_reg(REG_CNT, 16'h0000, "R3 wrapped count");
    chk_reg(REG_STAT, 16'h0010, "R3 wrap flag");
    chk_val({15'h0, irq}, 16'h0, "R9 irq masked");
    wr(REG_CTRL, 16'h4000);
    chk_reg(REG_CTRL, 16'h4000, "R12 ctrl readback");
    chk_val({15'h0, irq}, 16'h1, "R9 irq enabled");
    wr(REG_STAT, 16'h0001);
    chk_reg(REG_STAT, 16'h0010, "R9 other bit write keeps flag");
    wr(REG_STAT, 16'h0010);
    chk_reg(REG_STAT, 16'h0000, "R9 flag cleared");
    chk_val({15'h0, irq}, 16'h0, "R9 irq after clear");

    // R6 compare, R10 dma, R11 adc
    wr(REG_CTRL, 16'h0000);
    wr(REG_CMP1, 16'd5);
    wr(REG_CMP2, 16'd7);
    wr(REG_CNT, 16'd0);
    dma_cnt = 0; adc_cnt = 0;
    wr(REG_CTRL, 16'h0031);
    idle(10);
    wr(REG_CTRL, 16'h0000);
    idle(2);
    chk_reg(REG_STAT, 16'h000C, "R6 compare flags");
    chk_val({14'h0, oc_out}, 16'h3, "R6 outputs toggled");
    chk_val(16'(adc_cnt), 16'd1, "R11 adc pulses");
    chk_val(16'(dma_cnt), 16'd2, "R10 dma pulses");

    // R5 capture edge selection (counter stopped)
    wr(REG_STAT, 16'h001F);
    dma_cnt = 0;
    wr(REG_CNT, 16'h1234);
    wr(REG_CTRL, 16'h0240);
    cap_in = 2'b11;
    idle(5);
    chk_reg(REG_CAP1, 16'h1234, "R5 rising captured ch1");
    chk_reg(REG_CAP2, 16'h0000, "R5 rising ignored ch2");
    chk_reg(REG_STAT, 16'h0001, "R5 flag ch1 only");
    wr(REG_CNT, 16'h2222);
    cap_in = 2'b00;
    idle(5);
    chk_reg(REG_CAP1, 16'h1234, "R5 falling ignored ch1");
    chk_reg(REG_CAP2, 16'h2222, "R5 falling captured ch2");
    chk_reg(REG_STAT, 16'h0003, "R5 both flags");
    chk_val(16'(dma_cnt), 16'd0, "R10 no dma when disabled");
    wr(REG_STAT, 16'h001F);
    wr(REG_CTRL, 16'h00C0);
    wr(REG_CNT, 16'h3333);
    cap_in = 2'b11;
    idle(5);
    chk_reg(REG_CAP1, 16'h3333, "R5 both-edge rise ch1");
    chk_reg(REG_CAP2, 16'h2222, "R5 disabled ch2");
    wr(REG_CNT, 16'h4444);
    cap_in = 2'b00;
    idle(5);
    chk_reg(REG_CAP1, 16'h4444, "R5 both-edge fall ch1");
    chk_reg(REG_STAT, 16'h0001, "R5 disabled ch2 no flag");

    // R4 external clock
    wr(REG_CTRL, 16'h0000);
    wr(REG_CNT, 16'h0000);
    wr(REG_DIV, 16'h0003);
    wr(REG_CTRL, 16'h0003);
    repeat (6) begin
      ext_clk = 1'b1; idle(4);
      ext_clk = 1'b0; idle(4);
    end
    idle(4);
    wr(REG_CTRL, 16'h0000);
    chk_reg(REG_CNT, 16'd6, "R4 external edges counted");

    // R7 pulse-width mode
    wr(REG_DIV, 16'h0000);
    wr(REG_CMP1, 16'd3);
    wr(REG_CMP2, 16'd9);
    wr(REG_CNT, 16'd0);
    wr(REG_CTRL, 16'h0005);
    idle(12);
    bus_addr = REG_CNT;
    hi = 0; mx = 0;
    for (int i = 0; i < 20; i++) begin
      if (oc_out[0]) hi++;
      if (int'(bus_rdata) > mx) mx = int'(bus_rdata);
      @(negedge clk);
    end
    chk_val(16'(hi), 16'd6, "R7 duty cycles high");
    chk_val(16'(mx), 16'd9, "R7 count peak");

    // R8 single-shot mode
    wr(REG_CTRL, 16'h0000);
    wr(REG_STAT, 16'h001F);
    wr(REG_CMP1, 16'd4);
    wr(REG_CMP2, 16'hFFF0);
    wr(REG_CNT, 16'd0);
    wr(REG_CTRL, 16'h0009);
    idle(5);
    chk_reg(REG_CNT, 16'd0, "R8 idle before trigger");
    trig_in = 1'b1;
    count_high(20, hi);
    chk_val(16'(hi), 16'd5, "R8 pulse length");
    count_high(10, hi);
    chk_val(16'(hi), 16'd0, "R8 no retrigger on level");
    chk_reg(REG_CNT, 16'd0, "R8 counter back to 0");
    chk_reg(REG_STAT, 16'h0004, "R8 compare-1 flag");
    trig_in = 1'b0;
    idle(4);
    trig_in = 1'b1;
    count_high(20, hi);
    chk_val(16'(hi), 16'd5, "R8 second pulse");
    wr(REG_CTRL, 16'h0000);

    done = 1;
    summary();
    $finish;
  end

endmodule